// File: doc/BRIEF.md
# Embedded-Clock Word Deserializer with Lock Detect

This block takes a bit-synchronous serial stream, one bit per clock, that carries 12-bit frames. Each frame holds one 10-bit word between a start bit and a stop bit. Because the stop bit is low and the next start bit is high, there is a rising transition at every frame boundary. The block uses that transition to find the frame boundary. Once it has the boundary, it rebuilds the parallel word and produces a recovered word clock at one twelfth of the bit rate. It also produces an active-low lock flag, and the parallel output is to be trusted only while that flag is low.

While the block is not locked, it checks each 12-bit window for a valid start and stop pair. After every window that fails, it moves its frame boundary one bit later. It declares lock after several consecutive valid windows at the same offset. Once locked, it rides through a single corrupt frame. A second consecutive corrupt frame makes it drop lock and search again, and the last good word stays on the output.

A polarity input picks which edge of the recovered clock falls in the middle of the stable data. An output-enable input models the high-impedance state of the data and clock pins: it drives a drive-enable flag and forces those outputs to zero. A powerdown input clears the receiver and drops lock.

Top module: `emb_deser`

## Requirements
- R1: A frame is 12 bits in arrival order. Position 0 is the start bit (1), positions 1 to 10 carry data bits 0 to 9 (least significant bit first), and position 11 is the stop bit (0). A window is valid when its start bit is 1 and its stop bit is 0.
- R2: While locked, each valid frame loads its data onto `par_out`. The new word is visible in the cycle after the clock edge that samples the stop bit.
- R3: While unlocked, four consecutive valid windows at the same offset assert lock (`lock_n` goes to 0), and the fourth word is loaded at the same time. An invalid window resets this count and stretches the next window to 13 bits, which moves the boundary by one bit.
- R4: A stream of valid frames with all-zero data brings `lock_n` low within 1024 frame times, starting from any bit offset.
- R5: While locked, one invalid frame keeps lock and leaves `par_out` unchanged. A second consecutive invalid frame raises `lock_n` and leaves `par_out` unchanged.
- R6: The raw recovered clock is low for frame positions 0 to 5 and high for positions 6 to 11. With `rclk_inv` = 0 it drives `word_clk` as is, so the rising edge falls mid-word. With `rclk_inv` = 1, `word_clk` is the inverse.
- R7: With `out_en` = 0, `drive_en` is 0 and both `par_out` and `word_clk` are 0, while `lock_n` still reports lock. With `out_en` = 1, `drive_en` is 1.
- R8: Reset or `power_down` sets `lock_n` to 1 and clears `par_out` to 0. The search then starts again.
- R9: The internal data word changes only while locked, except when it is cleared by powerdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_down | input | 1 | Synchronous receiver clear, drops lock |
| ser_in | input | 1 | Serial data, one bit per clock |
| rclk_inv | input | 1 | Recovered clock polarity select |
| out_en | input | 1 | Output enable for data and recovered clock |
| par_out | output | 10 | Recovered parallel word |
| word_clk | output | 1 | Recovered word clock |
| lock_n | output | 1 | Active-low lock indicator |
| drive_en | output | 1 | High when data and clock outputs are driven |

## Verification
The hardest state to reach is the one-bit-slipped boundary after lock is lost. There the receiver has to walk through every offset, in 13-bit windows, before it finds the real boundary again. The bench gets there by sending exactly two frames with a zero start bit in a row, after one isolated bad frame has shown that lock holds. It then sends zero-data frames, which have only one valid offset, so that reacquisition cannot stop on a false boundary. A behavioural reference model with a bit queue follows every clock. It catches any error in the slip timing, the loss count or the instant the word is loaded.

// File: rtl/emb_deser.sv
module emb_deser #(
  parameter int DW          = 10,
  parameter int GOOD_FRAMES = 4,
  parameter int BAD_FRAMES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          power_down,
  input  logic          ser_in,
  input  logic          rclk_inv,
  input  logic          out_en,
  output logic [DW-1:0] par_out,
  output logic          word_clk,
  output logic          lock_n,
  output logic          drive_en
);
  localparam int FW = DW + 2;
  localparam int PW = $clog2(FW);
  localparam int GW = $clog2(GOOD_FRAMES + 1);
  localparam int BW = $clog2(BAD_FRAMES + 1);

  logic [FW-1:0] sr;
  logic [PW-1:0] pos;
  logic          hold;
  logic [GW-1:0] good;
  logic [BW-1:0] bad;
  logic          locked;
  logic [DW-1:0] data_q;

  wire [FW-1:0] frm     = {ser_in, sr[FW-1:1]};
  wire          last    = (pos == PW'(FW - 1)) && !hold;
  wire          frm_ok  = frm[0] && !frm[FW-1];
  wire          rclk_raw = (pos >= PW'(FW / 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; pos <= '0; hold <= 1'b0; good <= '0; bad <= '0;
      locked <= 1'b0; data_q <= '0;
    end else if (power_down) begin
      sr <= '0; pos <= '0; hold <= 1'b0; good <= '0; bad <= '0;
      locked <= 1'b0; data_q <= '0;
    end else begin
      sr <= frm;
      if (hold)      hold <= 1'b0;
      else if (last) pos  <= '0;
      else           pos  <= pos + 1'b1;
      if (last) begin
        if (frm_ok) begin
          bad <= '0;
          if (locked) begin
            data_q <= frm[DW:1];
          end else if (good == GW'(GOOD_FRAMES - 1)) begin
            locked <= 1'b1;
            good   <= '0;
            data_q <= frm[DW:1];
          end else begin
            good <= good + 1'b1;
          end
        end else if (locked && bad != BW'(BAD_FRAMES - 1)) begin
          bad <= bad + 1'b1;
        end else begin
          locked <= 1'b0;
          bad    <= '0;
          good   <= '0;
          hold   <= 1'b1;
        end
      end
    end
  end

  assign par_out  = out_en ? data_q : '0;
  assign word_clk = out_en & (rclk_raw ^ rclk_inv);
  assign lock_n   = !locked;
  assign drive_en = out_en;

  a_r1_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos < PW'(FW));

  a_r9_data_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(data_q) && !$past(power_down)) |-> locked);

  a_r3_lock_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(frm_ok) && $past(last)));

  a_r5_loss_on_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && !$past(power_down)) |-> (!$past(frm_ok) && $past(last) && $past(bad) != '0));

  a_r6_clk_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rclk_raw) |-> (pos == '0 || pos == PW'(FW / 2)));
endmodule

// File: tb/emb_deser_bench.sv
module emb_deser_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic power_down = 1'b0;
  logic ser_in = 1'b0;
  logic rclk_inv = 1'b0;
  logic out_en = 1'b1;
  logic [9:0] par_out;
  logic word_clk, lock_n, drive_en;

  int n_checks = 0;
  int n_fails  = 0;

  emb_deser u_emb_deser (
    .clk(clk), .rst_n(rst_n), .power_down(power_down), .ser_in(ser_in),
    .rclk_inv(rclk_inv), .out_en(out_en), .par_out(par_out),
    .word_clk(word_clk), .lock_n(lock_n), .drive_en(drive_en)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_pos, m_good, m_bad;
  bit m_hold, m_lock;
  bit [9:0] m_data;
  bit win[$];

  always @(posedge clk) begin
    if (!rst_n || power_down) begin
      m_pos = 0; m_good = 0; m_bad = 0; m_hold = 0; m_lock = 0; m_data = '0;
      win = {};
      for (int i = 0; i < 12; i++) win.push_back(1'b0);
    end else begin
      win.push_back(ser_in);
      win.delete(0);
      if (m_hold) m_hold = 0;
      else if (m_pos == 11) begin
        bit ok;
        bit [9:0] d;
        m_pos = 0;
        ok = (win[0] == 1'b1) && (win[11] == 1'b0);
        for (int i = 0; i < 10; i++) d[i] = win[1 + i];
        if (ok) begin
          m_bad = 0;
          if (m_lock) m_data = d;
          else if (m_good == 3) begin m_lock = 1; m_good = 0; m_data = d; end
          else m_good++;
        end else if (m_lock && m_bad == 0) begin
          m_bad = 1;
        end else begin
          m_lock = 0; m_bad = 0; m_good = 0; m_hold = 1;
        end
      end else m_pos++;
    end
    #(CLK_PERIOD / 4);
    begin
      bit [9:0] e_dout;
      bit e_clk;
      e_dout = out_en ? m_data : 10'h0;
      e_clk  = out_en & ((m_pos >= 6) ^ rclk_inv);
      chk(par_out == e_dout, "R2 R9 model par_out", par_out, e_dout);
      chk(lock_n == !m_lock, "R3 R5 model lock_n", lock_n, !m_lock);
      chk(word_clk == e_clk, "R6 model word_clk", word_clk, e_clk);
      chk(drive_en == out_en, "R7 model drive_en", drive_en, out_en);
    end
  end

  task automatic send_bit(input bit b);
    @(negedge clk);
    ser_in = b;
  endtask

  task automatic send_frame(input bit [9:0] d, input bit valid);
    send_bit(valid);
    for (int i = 0; i < 10; i++) send_bit(d[i]);
    send_bit(1'b0);
  endtask

  task automatic after_stop();
    @(posedge clk);
    #(CLK_PERIOD / 4);
  endtask

  task automatic acquire(input string req);
    int frames = 0;
    while (lock_n && frames < 1100) begin
      send_frame(10'h000, 1'b1);
      frames++;
    end
    chk(lock_n == 1'b0, req, lock_n, 0);
    chk(frames <= 1024 && frames >= 4, req, frames, 1024);
  endtask

  task automatic data_frame(input bit [9:0] d);
    send_frame(d, 1'b1);
    after_stop();
    chk(par_out == d, "R2 R1 word load", par_out, d);
    chk(word_clk == rclk_inv, "R6 clock at frame start", word_clk, rclk_inv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_PERIOD / 4);
    chk(lock_n == 1'b1, "R8 reset lock_n", lock_n, 1);
    chk(par_out == 10'h0, "R8 reset par_out", par_out, 0);
    @(negedge clk);
    rst_n = 1'b1;

    repeat (5) send_bit(1'b0);
    acquire("R4 R3 initial lock");

    data_frame(10'h2A5);
    data_frame(10'h15A);
    data_frame(10'h3FF);
    data_frame(10'h001);
    rclk_inv = 1'b1;
    data_frame(10'h200);
    data_frame(10'h0F0);
    rclk_inv = 1'b0;

    send_frame(10'h3C3, 1'b0);
    after_stop();
    chk(lock_n == 1'b0, "R5 single bad frame keeps lock", lock_n, 0);
    chk(par_out == 10'h0F0, "R5 single bad frame holds data", par_out, 10'h0F0);
    data_frame(10'h155);

    send_frame(10'h0AA, 1'b0);
    send_frame(10'h055, 1'b0);
    after_stop();
    chk(lock_n == 1'b1, "R5 two bad frames drop lock", lock_n, 1);
    chk(par_out == 10'h155, "R5 data held after loss", par_out, 10'h155);

    acquire("R3 R4 reacquire after slip");

    out_en = 1'b0;
    send_frame(10'h1E1, 1'b1);
    after_stop();
    chk(drive_en == 1'b0, "R7 drive_en off", drive_en, 0);
    chk(par_out == 10'h0, "R7 par_out forced", par_out, 0);
    chk(word_clk == 1'b0, "R7 word_clk forced", word_clk, 0);
    chk(lock_n == 1'b0, "R7 lock_n still reported", lock_n, 0);
    @(negedge clk);
    out_en = 1'b1;
    #(CLK_PERIOD / 4);
    chk(par_out == 10'h1E1, "R7 R2 word visible again", par_out, 10'h1E1);
    chk(drive_en == 1'b1, "R7 drive_en on", drive_en, 1);

    power_down = 1'b1;
    repeat (30) @(negedge clk);
    #(CLK_PERIOD / 4);
    chk(lock_n == 1'b1, "R8 powerdown drops lock", lock_n, 1);
    chk(par_out == 10'h0, "R8 powerdown clears data", par_out, 0);
    @(negedge clk);
    power_down = 1'b0;
    repeat (7) send_bit(1'b1);
    acquire("R8 R4 lock after powerdown");
    data_frame(10'h333);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired, run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule